// File: doc/BRIEF.md
# SD Command Line Engine

This block puts one host command onto the single-bit, open-line command wire of an SD/MMC card and then collects the card's answer. The controller presents a 6-bit command index and a 32-bit argument together with a start pulse and three mode bits: whether a reply is expected, whether that reply is the long (136-bit) kind, and whether the reply's CRC field is reserved and must not be checked. The engine builds the 48-bit command frame, appends a CRC7, and clocks it out one bit per cycle, most significant bit first.

When a reply is expected, the engine releases the line and waits a bounded number of cycles for the card's start bit. It then shifts in the reply, checks its CRC where one applies, and writes the payload into four 32-bit result words. Exactly one completion flag describes the outcome of each command: sent, received, CRC mismatch or no answer. All flags clear when the next command is accepted. Clock division, the data lines and any register access for software sit outside this block.

Top module: `sd_cmd_engine`

## Requirements
- R1: One cycle after a start pulse is taken while idle, `cmd_oe` goes high for exactly 48 cycles and `cmd_o` carries, MSB first: a 0, a 1, the 6-bit index, the 32-bit argument, a 7-bit CRC and a closing 1.
- R2: The 7-bit CRC is the remainder of the first 40 frame bits under the generator x^7 + x^3 + 1, starting from an all-zero register.
- R3: With no reply requested, `flag_sent` is high and `busy` low in the cycle right after the closing bit was driven, and no other flag is set.
- R4: With a reply requested, the engine watches `cmd_in` for 64 cycles starting the cycle after the closing bit; a low level in any of them is taken as the reply's start bit, and 64 high cycles set `flag_timeout` and leave all four result words unchanged.
- R5: A 48-bit reply whose last-but-one 7 bits equal the CRC of its first 40 bits sets `flag_recv`; `resp0` receives reply bits 39 down to 8 (the 32 bits after the 8 leading bits) and `resp1` to `resp3` keep their values.
- R6: A 48-bit reply with a wrong CRC sets `flag_crcerr`, leaves `flag_recv` low, and still loads `resp0` as in R5.
- R7: With `rsp_nocrc` set, a 48-bit reply sets `flag_recv` whatever its CRC field holds.
- R8: A long reply is 136 bits; its last 128 bits are stored so that `resp3[31]` holds the first of them and `resp0[0]` the last, words in descending order, and `flag_recv` is set with no CRC check.
- R9: At most one completion flag is high at any time, and all of them are low from the cycle after a command is accepted until it completes.
- R10: After reset `busy`, `cmd_oe`, all flags and all result words are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one line bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a command; taken only while idle |
| cmd_idx | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| rsp_en | input | 1 | A reply is expected |
| rsp_long | input | 1 | The reply is 136 bits long |
| rsp_nocrc | input | 1 | Skip the CRC check on a 48-bit reply |
| cmd_in | input | 1 | Command line as seen from the card side |
| cmd_o | output | 1 | Command line value driven by the host |
| cmd_oe | output | 1 | Host drives the command line |
| busy | output | 1 | A command is in progress |
| flag_sent | output | 1 | Command sent, no reply wanted |
| flag_recv | output | 1 | Reply received and accepted |
| flag_crcerr | output | 1 | Reply received with a CRC mismatch |
| flag_timeout | output | 1 | No reply start bit within the window |
| resp0 | output | 32 | Result word 0 (least significant) |
| resp1 | output | 32 | Result word 1 |
| resp2 | output | 32 | Result word 2 |
| resp3 | output | 32 | Result word 3 (most significant) |

## Verification
The assertions assume that `cmd_in` idles high and that the card answers only after the host has released the line, and that the mode bits are held steady while `busy` is high. The stimulus raises `start` only after `busy` has fallen, changes index, argument and mode bits only together with `start`, and drives `cmd_in` low only while replaying a reply frame. The timeout assertion relies on that idle-high line: it treats the window as expired only when the last watched sample was high.

// File: rtl/sdce_pkg.sv
package sdce_pkg;

  localparam int CMD_BITS  = 48;
  localparam int SHORT_BITS = 48;
  localparam int LONG_BITS = 136;
  localparam int WAIT_WIN  = 64;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_WAIT,
    RX_BITS
  } rx_state_t;

  // Serial CRC7, generator x^7 + x^3 + 1, register starts at zero.
  function automatic logic [6:0] crc7_calc(input logic [39:0] msg);
    logic [6:0] c;
    logic       fb;
    c = 7'd0;
    for (int i = 39; i >= 0; i--) begin
      fb = c[6] ^ msg[i];
      c  = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction

  function automatic logic [47:0] cmd_frame(input logic [5:0] idx, input logic [31:0] arg);
    logic [39:0] head;
    head = {1'b0, 1'b1, idx, arg};
    return {head, crc7_calc(head), 1'b1};
  endfunction

endpackage

// File: rtl/sdce_cmd_tx.sv
module sdce_cmd_tx #(
  parameter int FRAME_W = 48
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame,
  output logic               line,
  output logic               oe,
  output logic               last
);
  localparam int CNT_W = $clog2(FRAME_W);

  logic [FRAME_W-1:0] sh;
  logic [CNT_W-1:0]   cnt;
  logic               act;

  // Named event: the closing bit is on the line this cycle.
  assign last = act && (cnt == CNT_W'(FRAME_W - 1));
  assign line = act ? sh[FRAME_W-1] : 1'b1;
  assign oe   = act;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh  <= '0;
      cnt <= '0;
      act <= 1'b0;
    end else if (load) begin
      sh  <= frame;
      cnt <= '0;
      act <= 1'b1;
    end else if (act) begin
      sh  <= {sh[FRAME_W-2:0], 1'b1};
      cnt <= cnt + 1'b1;
      if (last) act <= 1'b0;
    end
  end

  a_r1_release_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> !oe);
  a_r1_load_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !oe);

endmodule

// File: rtl/sdce_rsp_rx.sv
module sdce_rsp_rx
  import sdce_pkg::*;
#(
  parameter int LONG_W   = 136,
  parameter int SHORT_W  = 48,
  parameter int WAIT_CYC = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              long_sel,
  input  logic              line,
  output logic              done,
  output logic              tmo,
  output logic [LONG_W-1:0] frame
);
  localparam int RC_W = $clog2(LONG_W + 1);
  localparam int WC_W = $clog2(WAIT_CYC);

  rx_state_t       st;
  logic [RC_W-1:0] rcnt;
  logic [WC_W-1:0] wcnt;
  logic            long_q;
  logic [RC_W-1:0] need;
  logic            start_seen;
  logic            wait_expired;

  assign need         = long_q ? RC_W'(LONG_W) : RC_W'(SHORT_W);
  assign start_seen   = (st == RX_WAIT) && !line;
  assign wait_expired = (st == RX_WAIT) && line && (wcnt == WC_W'(WAIT_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= RX_IDLE;
      rcnt   <= '0;
      wcnt   <= '0;
      long_q <= 1'b0;
      frame  <= '0;
      done   <= 1'b0;
      tmo    <= 1'b0;
    end else begin
      done <= 1'b0;
      tmo  <= 1'b0;
      case (st)
        RX_IDLE: begin
          if (arm) begin
            st     <= RX_WAIT;
            wcnt   <= '0;
            long_q <= long_sel;
          end
        end
        RX_WAIT: begin
          if (start_seen) begin
            st    <= RX_BITS;
            frame <= '0;
            rcnt  <= RC_W'(1);
          end else if (wait_expired) begin
            tmo <= 1'b1;
            st  <= RX_IDLE;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        RX_BITS: begin
          frame <= {frame[LONG_W-2:0], line};
          rcnt  <= rcnt + 1'b1;
          if (rcnt == need - 1'b1) begin
            done <= 1'b1;
            st   <= RX_IDLE;
          end
        end
        default: st <= RX_IDLE;
      endcase
    end
  end

  a_r4_arm_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    arm |-> (st == RX_IDLE));
  a_r4_timeout_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |-> $past(line));
  a_r8_done_from_bits: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(st == RX_BITS));
  a_r9_done_tmo_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && tmo));

endmodule

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine
  import sdce_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [5:0]  cmd_idx,
  input  logic [31:0] cmd_arg,
  input  logic        rsp_en,
  input  logic        rsp_long,
  input  logic        rsp_nocrc,
  input  logic        cmd_in,
  output logic        cmd_o,
  output logic        cmd_oe,
  output logic        busy,
  output logic        flag_sent,
  output logic        flag_recv,
  output logic        flag_crcerr,
  output logic        flag_timeout,
  output logic [31:0] resp0,
  output logic [31:0] resp1,
  output logic [31:0] resp2,
  output logic [31:0] resp3
);
  logic                 accept;
  logic                 tx_last;
  logic                 rx_done;
  logic                 rx_tmo;
  logic [LONG_BITS-1:0] rx_frame;
  logic                 ren_q, long_q, nocrc_q;
  logic                 ev_sent, ev_recv, ev_crcerr;
  logic                 short_crc_ok, skip_crc;

  assign accept = start && !busy;

  sdce_cmd_tx #(.FRAME_W(CMD_BITS)) u_tx (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .frame (cmd_frame(cmd_idx, cmd_arg)),
    .line  (cmd_o),
    .oe    (cmd_oe),
    .last  (tx_last)
  );

  sdce_rsp_rx #(.LONG_W(LONG_BITS), .SHORT_W(SHORT_BITS), .WAIT_CYC(WAIT_WIN)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm      (tx_last && ren_q),
    .long_sel (long_q),
    .line     (cmd_in),
    .done     (rx_done),
    .tmo      (rx_tmo),
    .frame    (rx_frame)
  );

  assign short_crc_ok = (crc7_calc(rx_frame[47:8]) == rx_frame[7:1]);
  assign skip_crc     = long_q || nocrc_q;
  assign ev_sent      = tx_last && !ren_q;
  assign ev_recv      = rx_done && (skip_crc || short_crc_ok);
  assign ev_crcerr    = rx_done && !skip_crc && !short_crc_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy         <= 1'b0;
      ren_q        <= 1'b0;
      long_q       <= 1'b0;
      nocrc_q      <= 1'b0;
      flag_sent    <= 1'b0;
      flag_recv    <= 1'b0;
      flag_crcerr  <= 1'b0;
      flag_timeout <= 1'b0;
      resp0        <= '0;
      resp1        <= '0;
      resp2        <= '0;
      resp3        <= '0;
    end else if (accept) begin
      busy         <= 1'b1;
      ren_q        <= rsp_en;
      long_q       <= rsp_long;
      nocrc_q      <= rsp_nocrc;
      flag_sent    <= 1'b0;
      flag_recv    <= 1'b0;
      flag_crcerr  <= 1'b0;
      flag_timeout <= 1'b0;
    end else begin
      if (ev_sent || rx_done || rx_tmo) busy <= 1'b0;
      if (ev_sent)   flag_sent    <= 1'b1;
      if (ev_recv)   flag_recv    <= 1'b1;
      if (ev_crcerr) flag_crcerr  <= 1'b1;
      if (rx_tmo)    flag_timeout <= 1'b1;
      if (rx_done) begin
        if (long_q) begin
          resp3 <= rx_frame[127:96];
          resp2 <= rx_frame[95:64];
          resp1 <= rx_frame[63:32];
          resp0 <= rx_frame[31:0];
        end else begin
          resp0 <= rx_frame[39:8];
        end
      end
    end
  end

  a_r9_flags_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({flag_sent, flag_recv, flag_crcerr, flag_timeout}));
  a_r9_clear_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !(flag_sent || flag_recv || flag_crcerr || flag_timeout));
  a_r1_idle_line_released: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cmd_oe);
  a_r3_sent_after_drive: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_sent) |-> ($past(cmd_oe) && !cmd_oe));
  a_r8_long_never_crcerr: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_crcerr) |-> !long_q);

endmodule

// File: tb/sd_cmd_engine_bench.sv
module sd_cmd_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [5:0]  cmd_idx = '0;
  logic [31:0] cmd_arg = '0;
  logic        rsp_en = 1'b0, rsp_long = 1'b0, rsp_nocrc = 1'b0;
  logic        cmd_in = 1'b1;
  logic        cmd_o, cmd_oe, busy;
  logic        flag_sent, flag_recv, flag_crcerr, flag_timeout;
  logic [31:0] resp0, resp1, resp2, resp3;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  sd_cmd_engine u_sd_cmd_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_idx(cmd_idx), .cmd_arg(cmd_arg),
    .rsp_en(rsp_en), .rsp_long(rsp_long), .rsp_nocrc(rsp_nocrc), .cmd_in(cmd_in),
    .cmd_o(cmd_o), .cmd_oe(cmd_oe), .busy(busy), .flag_sent(flag_sent),
    .flag_recv(flag_recv), .flag_crcerr(flag_crcerr), .flag_timeout(flag_timeout),
    .resp0(resp0), .resp1(resp1), .resp2(resp2), .resp3(resp3)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Long division by 0x89 over the 40 head bits shifted up by 7.
  function automatic logic [6:0] ref_crc(input logic [39:0] m);
    logic [46:0] r;
    r = {m, 7'd0};
    for (int i = 46; i >= 7; i--)
      if (r[i]) r[i -: 8] = r[i -: 8] ^ 8'h89;
    return r[6:0];
  endfunction

  function automatic logic [3:0] flags();
    return {flag_sent, flag_recv, flag_crcerr, flag_timeout};
  endfunction

  task automatic send_cmd(input logic [5:0] idx, input logic [31:0] arg, input bit en,
                          input bit lng, input bit nocrc, output logic [47:0] cap, output bit oe_ok);
    @(negedge clk);
    cmd_idx = idx; cmd_arg = arg; rsp_en = en; rsp_long = lng; rsp_nocrc = nocrc;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    oe_ok = 1'b1;
    chk(busy && flags() == 4'd0, "R9 flags cleared on accept", {busy, flags()}, 5'h10);
    for (int k = 0; k < 48; k++) begin
      if (k != 0) @(negedge clk);
      cap[47-k] = cmd_o;
      if (!cmd_oe) oe_ok = 1'b0;
    end
  endtask

  task automatic drive_resp(input logic [135:0] bits, input int n, input int delay);
    repeat (delay) @(negedge clk);
    for (int k = n - 1; k >= 0; k--) begin
      @(negedge clk);
      cmd_in = bits[k];
    end
    @(negedge clk);
    cmd_in = 1'b1;
  endtask

  task automatic wait_idle();
    int guard;
    guard = 0;
    while (busy && guard < 400) begin
      @(negedge clk);
      guard++;
    end
  endtask

  function automatic logic [47:0] short_rsp(input logic [5:0] idx, input logic [31:0] pay, input bit bad);
    logic [39:0] h;
    logic [6:0]  c;
    h = {2'b00, idx, pay};
    c = ref_crc(h);
    if (bad) c = c ^ 7'h01;
    return {h, c, 1'b1};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [47:0] cap, exp;
    logic [31:0] r1s, r2s, r3s, r0s;
    logic [127:0] lp;
    bit oe_ok;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(!busy && !cmd_oe && flags() == 0, "R10 reset control", {busy, cmd_oe, flags()}, 0);
    chk({resp3, resp2, resp1, resp0} == 0, "R10 reset result words", {resp3, resp2, resp1, resp0}, 0);

    // R1 R2 R3: every index, no reply
    for (int i = 0; i < 64; i++) begin
      logic [31:0] a;
      a = (32'(i) * 32'h9E37_79B1) ^ {i[7:0], 24'h5A3C_0F};
      send_cmd(6'(i), a, 0, 0, 0, cap, oe_ok);
      exp = {2'b01, 6'(i), a, ref_crc({2'b01, 6'(i), a}), 1'b1};
      chk(cap == exp, "R1 R2 frame bits and CRC7", cap, exp);
      chk(oe_ok, "R1 line driven for 48 cycles", oe_ok, 1);
      @(negedge clk);
      chk(!cmd_oe, "R1 line released after closing bit", cmd_oe, 0);
      chk(!busy && flags() == 4'b1000, "R3 sent flag right after closing bit", {busy, flags()}, 5'b01000);
    end

    // R8 long reply
    lp = {32'hA5C3_0F81, 32'h1234_5678, 32'hDEAD_BEEF, 32'h8000_0001};
    send_cmd(6'd2, 32'h0, 1, 1, 0, cap, oe_ok);
    drive_resp({2'b00, 6'h3F, lp}, 136, 5);
    wait_idle();
    chk(flag_recv && flags() == 4'b0100, "R8 long reply received", flags(), 4'b0100);
    chk(resp3 == lp[127:96], "R8 resp3 holds first bits", resp3, lp[127:96]);
    chk(resp2 == lp[95:64], "R8 resp2", resp2, lp[95:64]);
    chk(resp1 == lp[63:32], "R8 resp1", resp1, lp[63:32]);
    chk(resp0 == lp[31:0], "R8 resp0 bit0 is last bit", resp0, lp[31:0]);
    // R8 with a bit pattern that would fail any CRC check
    lp = ~lp;
    send_cmd(6'd9, 32'h1, 1, 1, 0, cap, oe_ok);
    drive_resp({2'b00, 6'h00, lp}, 136, 0);
    wait_idle();
    chk(flags() == 4'b0100 && {resp3, resp2, resp1, resp0} == lp, "R8 long inverted pattern",
        {resp3, resp2, resp1, resp0}, lp);

    // R5 short replies across the wait window
    for (int i = 0; i < 8; i++) begin
      logic [31:0] pay;
      pay = 32'h0F1E_2D3C * 32'(i + 3) ^ 32'(i);
      r1s = resp1; r2s = resp2; r3s = resp3;
      send_cmd(6'(i + 10), pay ^ 32'hFFFF, 1, 0, 0, cap, oe_ok);
      drive_resp(136'(short_rsp(6'(i + 10), pay, 0)), 48, i * 9);
      wait_idle();
      chk(flags() == 4'b0100, "R5 good CRC sets recv", flags(), 4'b0100);
      chk(resp0 == pay, "R5 resp0 payload", resp0, pay);
      chk(resp1 == r1s && resp2 == r2s && resp3 == r3s, "R5 upper words kept",
          {resp3, resp2, resp1}, {r3s, r2s, r1s});
    end

    // R6 bad CRC
    send_cmd(6'd13, 32'h77, 1, 0, 0, cap, oe_ok);
    drive_resp(136'(short_rsp(6'd13, 32'hCAFE_F00D, 1)), 48, 2);
    wait_idle();
    chk(flags() == 4'b0010, "R6 bad CRC sets crcerr only", flags(), 4'b0010);
    chk(resp0 == 32'hCAFE_F00D, "R6 resp0 still loaded", resp0, 32'hCAFE_F00D);

    // R7 reserved CRC field
    send_cmd(6'd41, 32'h0, 1, 0, 1, cap, oe_ok);
    drive_resp(136'(short_rsp(6'd63, 32'h80FF_8000, 1)), 48, 1);
    wait_idle();
    chk(flags() == 4'b0100, "R7 nocrc sets recv", flags(), 4'b0100);
    chk(resp0 == 32'h80FF_8000, "R7 resp0 payload", resp0, 32'h80FF_8000);

    // R4 start bit in the last watched cycle
    send_cmd(6'd7, 32'h5, 1, 0, 0, cap, oe_ok);
    drive_resp(136'(short_rsp(6'd7, 32'h0BAD_CAFE, 0)), 48, 63);
    wait_idle();
    chk(flags() == 4'b0100 && resp0 == 32'h0BAD_CAFE, "R4 start bit on cycle 64 accepted",
        {flags(), resp0}, {4'b0100, 32'h0BAD_CAFE});

    // R4 no answer at all
    r0s = resp0; r1s = resp1; r2s = resp2; r3s = resp3;
    send_cmd(6'd8, 32'h1AA, 1, 0, 0, cap, oe_ok);
    repeat (63) @(negedge clk);
    chk(busy && flags() == 0, "R4 still waiting at cycle 63", {busy, flags()}, 5'h10);
    wait_idle();
    chk(flags() == 4'b0001, "R4 timeout flag", flags(), 4'b0001);
    chk({resp3, resp2, resp1, resp0} == {r3s, r2s, r1s, r0s}, "R4 result words unchanged",
        {resp3, resp2, resp1, resp0}, {r3s, r2s, r1s, r0s});

    // R4 late start bit (one cycle past the window) is not taken
    send_cmd(6'd8, 32'h1AA, 1, 0, 0, cap, oe_ok);
    drive_resp(136'(short_rsp(6'd8, 32'h1111_2222, 0)), 48, 64);
    wait_idle();
    chk(flags() == 4'b0001 && resp0 == r0s, "R4 late reply ignored", {flags(), resp0}, {4'b0001, r0s});

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule